// File: doc/BRIEF.md
# Strain-Slope Steady-State Detector

This block watches a stream of strain-gauge samples coming from an ADC (nominally at 30 MHz) and decides when the mechanical actuator behind the gauge has come to rest. Each sample is first passed through a moving-average filter of power-of-two length. The filtered stream is then differenced against its own value a fixed number of samples earlier. The magnitude of that difference is compared with a threshold supplied by the controller. Because only differences are used, a constant bias on the gauge output has no effect on the decision.

While the arm input is high, the detector tracks the motion. Once the slope has risen above the threshold at least once and then stayed below it for a programmed run of consecutive samples, it raises `settled`. If a programmed number of samples passes after arming and the slope never rises above the threshold, it raises `no_motion`. This flag tells the controller that the feedback path is not responding. Dropping arm clears both flags and all counters. The filter and difference pipeline keeps running whether or not the detector is armed.

Top module: `strain_settle_detect`

## Requirements
- R1: The filter output for sample k is the floor of the sum of samples k..k-3 divided by 4 (length 2^AVG_LOG2, default 4). Samples before the first one count as zero. The filter runs on every valid sample, whether or not arm is high.
- R2: On each valid sample, `slope` (signed, two's complement) becomes the filter output for that sample minus the filter output GAP (default 4) samples earlier. It is updated one clock after the valid edge and holds its value when `smp_valid` is low.
- R3: `slope_ok` goes high one clock after the 8th valid sample since reset (AVG_N+GAP) and stays high. Before that, neither flag can be set.
- R4: A constant offset added to every sample leaves `slope` unchanged once the history is full.
- R5: A slope sample counts as motion only when |slope| > thresh. It counts as quiet only when |slope| < thresh. A magnitude equal to thresh counts as neither.
- R6: While armed, `settled` is high after a quiet slope sample that completes a run of `hold_len` consecutive quiet samples (0 acts as 1), provided motion was seen on an earlier sample since arming. It falls on the next sample that is not quiet.
- R7: While armed, `no_motion` goes high on the slope sample that brings the count of slope samples since arming to `timeout` if none of them was motion. It stays high until disarmed.
- R8: With arm low, `settled`, `no_motion` and the run, motion and timeout counters clear at the next clock edge and nothing is counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| arm | input | 1 | Detector enable; low clears flags and counters |
| smp_valid | input | 1 | Sample strobe |
| smp_data | input | DW (12) | Unsigned ADC sample |
| thresh | input | DW (12) | Slope magnitude threshold |
| hold_len | input | HOLD_W (8) | Consecutive quiet samples needed for settled |
| timeout | input | TMO_W (16) | Slope samples allowed without motion |
| slope | output | DW+1 (13) | Signed filtered difference |
| slope_ok | output | 1 | Slope history is full |
| settled | output | 1 | Actuator at rest |
| no_motion | output | 1 | Feedback never moved after arming |

## Verification
Every result of this block (`slope`, `slope_ok`, `settled`, `no_motion`) is due exactly one clock after the rising edge that takes a valid sample. The clearing on disarm is also due one clock after the edge that sees arm low. The bench drives each sample on a falling edge, holds the strobe for one cycle and reads all outputs on the following falling edge. This is half a cycle after the register that produces them has updated, so the edge-to-result count is the same for every check. A step, hold and step-down vector sequence is checked sample by sample against precomputed slopes and flags. Directed cases then cover the timeout, the threshold-equality boundary and bias immunity.

// File: rtl/strain_settle_detect.sv
module strain_settle_detect #(
  parameter int DW       = 12,
  parameter int AVG_LOG2 = 2,
  parameter int GAP      = 4,
  parameter int HOLD_W   = 8,
  parameter int TMO_W    = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 arm,
  input  logic                 smp_valid,
  input  logic [DW-1:0]        smp_data,
  input  logic [DW-1:0]        thresh,
  input  logic [HOLD_W-1:0]    hold_len,
  input  logic [TMO_W-1:0]     timeout,
  output logic signed [DW:0]   slope,
  output logic                 slope_ok,
  output logic                 settled,
  output logic                 no_motion
);
  localparam int AVG_N = 1 << AVG_LOG2;
  localparam int SUMW  = DW + AVG_LOG2;
  localparam int SW    = DW + 1;
  localparam int FILL  = AVG_N + GAP;
  localparam int FILLW = $clog2(FILL + 1);

  logic [DW-1:0]     win [AVG_N];
  logic [DW-1:0]     hist [GAP];
  logic [SUMW-1:0]   sum_q;
  logic [FILLW-1:0]  fill_q;
  logic [HOLD_W-1:0] run_q;
  logic [TMO_W-1:0]  tcnt_q;
  logic              moved_q;

  wire [SUMW-1:0] sum_nxt  = sum_q + SUMW'(smp_data) - SUMW'(win[AVG_N-1]);
  wire [SUMW-1:0] sum_shr  = sum_nxt >> AVG_LOG2;
  wire [DW-1:0]   filt_nxt = sum_shr[DW-1:0];
  wire signed [SW-1:0] diff = $signed({1'b0, filt_nxt}) - $signed({1'b0, hist[GAP-1]});
  wire signed [SW-1:0] ndiff = -diff;
  wire [SW-1:0]   mag   = diff[SW-1] ? $unsigned(ndiff) : $unsigned(diff);
  wire            above = mag > {1'b0, thresh};
  wire            below = mag < {1'b0, thresh};
  wire            take  = smp_valid && (fill_q >= FILLW'(FILL - 1));

  wire [HOLD_W-1:0] hold_eff = (hold_len == '0) ? HOLD_W'(1) : hold_len;
  wire [HOLD_W-1:0] run_nxt  = !below ? '0 : (&run_q ? run_q : run_q + 1'b1);
  wire [TMO_W-1:0]  tc_nxt   = &tcnt_q ? tcnt_q : tcnt_q + 1'b1;
  wire              mv_nxt   = moved_q | above;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < AVG_N; i++) win[i] <= '0;
      for (int i = 0; i < GAP; i++) hist[i] <= '0;
      sum_q    <= '0;
      fill_q   <= '0;
      slope    <= '0;
      slope_ok <= 1'b0;
    end else if (smp_valid) begin
      for (int i = AVG_N - 1; i > 0; i--) win[i] <= win[i-1];
      win[0] <= smp_data;
      for (int i = GAP - 1; i > 0; i--) hist[i] <= hist[i-1];
      hist[0] <= filt_nxt;
      sum_q   <= sum_nxt;
      slope   <= diff;
      if (fill_q != FILLW'(FILL)) fill_q <= fill_q + 1'b1;
      if (take) slope_ok <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !arm) begin
      run_q     <= '0;
      tcnt_q    <= '0;
      moved_q   <= 1'b0;
      settled   <= 1'b0;
      no_motion <= 1'b0;
    end else if (take) begin
      run_q     <= run_nxt;
      tcnt_q    <= tc_nxt;
      moved_q   <= mv_nxt;
      settled   <= moved_q & below & (run_nxt >= hold_eff);
      no_motion <= no_motion | (!mv_nxt & (tc_nxt >= timeout));
    end
  end

  a_r8_disarm_clears: assert property (@(posedge clk) disable iff (!rst_n)
    !arm |=> (!settled && !no_motion));
  a_r2_slope_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !smp_valid |=> $stable(slope));
  a_r3_no_early_flags: assert property (@(posedge clk) disable iff (!rst_n)
    !slope_ok |-> (!settled && !no_motion));
  a_r6_settle_needs_motion: assert property (@(posedge clk) disable iff (!rst_n)
    settled |-> moved_q);
  a_r7_fault_only_still: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(no_motion) |-> !moved_q);
endmodule

// File: tb/tb_strain_settle_detect.sv
`timescale 1ns/1ps
module tb_strain_settle_detect;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic arm = 1'b0;
  logic smp_valid = 1'b0;
  logic [11:0] smp_data = '0;
  logic [11:0] thresh = 12'd50;
  logic [7:0]  hold_len = 8'd3;
  logic [15:0] timeout = 16'd100;
  logic signed [12:0] slope;
  logic slope_ok, settled, no_motion;
  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  strain_settle_detect dut (
    .clk, .rst_n, .arm, .smp_valid, .smp_data, .thresh, .hold_len, .timeout,
    .slope, .slope_ok, .settled, .no_motion
  );

  // data, expected slope, slope_ok, settled
  localparam int TBL [26][4] = '{
    '{0,0,0,0}, '{0,0,0,0}, '{0,0,0,0}, '{0,0,0,0},
    '{0,0,0,0}, '{0,0,0,0}, '{0,0,0,0}, '{0,0,1,0},
    '{400,100,1,0}, '{400,200,1,0}, '{400,300,1,0}, '{400,400,1,0},
    '{400,300,1,0}, '{400,200,1,0}, '{400,100,1,0}, '{400,0,1,0},
    '{100,-75,1,0}, '{100,-150,1,0}, '{100,-225,1,0}, '{100,-300,1,0},
    '{100,-225,1,0}, '{100,-150,1,0}, '{100,-75,1,0}, '{100,0,1,0},
    '{100,0,1,0}, '{100,0,1,1}
  };

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic send(input int d);
    smp_valid = 1'b1;
    smp_data  = 12'(d);
    @(negedge clk);
    smp_valid = 1'b0;
  endtask

  task automatic idle();
    @(negedge clk);
  endtask

  initial begin
    #500000;
    errors++;
    $display("FAIL watchdog actual hung expected done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    idle();
    chk("R3 reset slope_ok", int'(slope_ok), 0);
    chk("R8 reset settled", int'(settled), 0);
    chk("R7 reset no_motion", int'(no_motion), 0);
    chk("R2 reset slope", int'(slope), 0);

    arm = 1'b1;
    idle();
    for (int k = 0; k < 26; k++) begin
      send(TBL[k][0]);
      chk($sformatf("R1 R2 slope k%0d", k), int'(slope), TBL[k][1]);
      chk($sformatf("R3 slope_ok k%0d", k), int'(slope_ok), TBL[k][2]);
      chk($sformatf("R6 settled k%0d", k), int'(settled), TBL[k][3]);
      chk($sformatf("R7 no_motion k%0d", k), int'(no_motion), 0);
    end
    idle();
    chk("R2 slope held without strobe", int'(slope), 0);

    // R8: disarm clears settled
    arm = 1'b0;
    idle();
    chk("R8 disarm clears settled", int'(settled), 0);

    // R7: timeout of 5 with a flat signal
    timeout = 16'd5; thresh = 12'd50; hold_len = 8'd3; arm = 1'b1;
    for (int i = 1; i <= 5; i++) begin
      send(100);
      chk($sformatf("R7 no_motion sample %0d", i), int'(no_motion), (i == 5) ? 1 : 0);
      chk($sformatf("R6 flat not settled %0d", i), int'(settled), 0);
    end
    idle();
    chk("R7 no_motion sticky", int'(no_motion), 1);
    arm = 1'b0;
    idle();
    chk("R8 disarm clears no_motion", int'(no_motion), 0);

    // R5: slope equal to thresh is not motion
    timeout = 16'd1; thresh = 12'd50; arm = 1'b1;
    send(300);
    chk("R5 equal slope value", int'(slope), 50);
    chk("R5 equal is not motion", int'(no_motion), 1);
    arm = 1'b0;
    idle();

    // R8: samples while disarmed raise nothing
    for (int i = 0; i < 8; i++) send(100);
    chk("R8 disarmed no_motion", int'(no_motion), 0);
    chk("R8 disarmed settled", int'(settled), 0);

    // R5: slope just above thresh is motion
    thresh = 12'd49; arm = 1'b1;
    send(300);
    chk("R5 above slope value", int'(slope), 50);
    chk("R5 above is motion", int'(no_motion), 0);
    arm = 1'b0;
    idle();

    // R4: bias offset leaves step slope unchanged
    for (int i = 0; i < 8; i++) send(2000);
    chk("R4 flat biased slope", int'(slope), 0);
    send(2400);
    chk("R4 biased step slope 1", int'(slope), 100);
    send(2400);
    chk("R4 biased step slope 2", int'(slope), 200);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule